// File: doc/BRIEF.md
# DMA Request and Interrupt Pin Test Register Block

This block sits between a DMA channel engine and the chip-level peripheral request pins and interrupt lines. It sits on the path in both directions. Peripheral request lines pass through it towards the engine. On the way, four software request registers can add requests to them, one register for each request kind: burst, single, last-burst and last-single. Acknowledge, terminal-count and interrupt lines from the engine pass through it towards the pins.

A mode bit selects one of two sources for those pin outputs:

- In functional mode, the pins follow the engine.
- In test mode, the pins are driven from three test output registers.

Reading a software request register returns the merged request value that the engine sees. Reading a test output register returns what is on the pins. This gives software a way to check board-level wiring and the interrupt controller path without running transfers.

Access is through a plain register port. Writes are registered on the clock edge. Reads are combinational on the address.

Top module: `dmait_top`

## Requirements
- R1: After reset, every register is zero. Test mode is off, all software requests are clear and the test output registers hold zero.
- R2: Each request group presented to the engine is the bitwise OR of the peripheral input and the software register of that group. Bit 0 of a group's software register maps to lane 0 of that group.
- R3: The software request registers are at word addresses 1 (burst), 2 (single), 3 (last-burst) and 4 (last-single). A read of one of them returns the merged value of its group in bits 15:0 and zero above. A write to one of them affects only that group.
- R4: A software request bit keeps its value until software writes that register again. It does not clear when the peripheral input changes or time passes.
- R5: When test mode is off, the acknowledge, terminal-count, error-interrupt and count-interrupt pins equal the engine's outputs in the same cycle.
- R6: Address 0 bit 0 is the test mode bit. When it is set, the acknowledge pins come from the register at address 5 and the terminal-count pins come from the register at address 6. A write to those registers while test mode is off does not change the pins.
- R7: In test mode, bit 0 of the register at address 7 drives the error interrupt pin and bit 1 drives the count interrupt pin.
- R8: A read of addresses 5, 6 and 7 returns the current pin values (address 7: bit 0 error, bit 1 count), in either mode.
- R9: The combined interrupt pin is the OR of the error and count interrupt pins after the mode selection. This means test-mode writes also exercise it.
- R10: Any address above 7 reads as zero, and writes there change no register.
- R11: A write takes effect in the cycle after the clock edge that captures it. A read reflects the current state within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | AW (8) | Word address |
| reg_wdata | input | DW (32) | Write data |
| reg_rdata | output | DW (32) | Read data, combinational on reg_addr |
| hw_burst_req | input | NREQ (16) | Peripheral burst requests |
| hw_single_req | input | NREQ (16) | Peripheral single requests |
| hw_lburst_req | input | NREQ (16) | Peripheral last-burst requests |
| hw_lsingle_req | input | NREQ (16) | Peripheral last-single requests |
| core_burst_req | output | NREQ (16) | Merged burst requests to the engine |
| core_single_req | output | NREQ (16) | Merged single requests to the engine |
| core_lburst_req | output | NREQ (16) | Merged last-burst requests to the engine |
| core_lsingle_req | output | NREQ (16) | Merged last-single requests to the engine |
| core_clr_ack | input | NREQ (16) | Request clear acknowledges from the engine |
| core_tc | input | NREQ (16) | Terminal-count flags from the engine |
| core_int_err | input | 1 | Error interrupt from the engine |
| core_int_tc | input | 1 | Count interrupt from the engine |
| pin_clr_ack | output | NREQ (16) | Acknowledge pins after the mode selection |
| pin_tc | output | NREQ (16) | Terminal-count pins after the mode selection |
| pin_int_err | output | 1 | Error interrupt pin |
| pin_int_tc | output | 1 | Count interrupt pin |
| pin_int_any | output | 1 | Combined interrupt pin |

## Verification
The only register stage is the write path. A written value therefore appears on the merged requests, the pins and the readback one time unit after the capturing clock edge. Before that edge, the old value must still be present.

Engine-to-pin and peripheral-to-engine paths have no register at all. The bench changes those inputs on the falling edge and samples after a short settle delay, within the same cycle. Reads follow the same pattern: the bench sets the address, waits a settle delay and compares, without waiting for a clock edge.

// File: rtl/dmait_pkg.sv
package dmait_pkg;
    localparam int NUM_GROUPS = 4;

    typedef enum logic [2:0] {
        A_CTRL       = 3'd0,
        A_SW_BURST   = 3'd1,
        A_SW_SINGLE  = 3'd2,
        A_SW_LBURST  = 3'd3,
        A_SW_LSINGLE = 3'd4,
        A_TO_CLR     = 3'd5,
        A_TO_TC      = 3'd6,
        A_TO_INT     = 3'd7
    } dmait_addr_e;
endpackage

// File: rtl/dmait_regs.sv
module dmait_regs
    import dmait_pkg::*;
#(
    parameter int NREQ = 16,
    parameter int AW   = 8,
    parameter int DW   = 32
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [AW-1:0]                        addr,
    input  logic [DW-1:0]                        wdata,
    output logic                                 test_mode,
    output logic [NUM_GROUPS-1:0][NREQ-1:0]      sw_req,
    output logic [NREQ-1:0]                      to_clr,
    output logic [NREQ-1:0]                      to_tc,
    output logic [1:0]                           to_int
);
    typedef struct packed {
        logic                            test;
        logic [NUM_GROUPS-1:0][NREQ-1:0] sw;
        logic [NREQ-1:0]                 clr;
        logic [NREQ-1:0]                 tc;
        logic [1:0]                      irq;
    } regs_t;

    regs_t st_d, st_q;
    logic  in_range;

    assign in_range = ((addr >> 3) == '0);

    always_comb begin
        st_d = st_q;
        if (wr_en && in_range) begin
            case (dmait_addr_e'(addr[2:0]))
                A_CTRL:       st_d.test  = wdata[0];
                A_SW_BURST:   st_d.sw[0] = wdata[NREQ-1:0];
                A_SW_SINGLE:  st_d.sw[1] = wdata[NREQ-1:0];
                A_SW_LBURST:  st_d.sw[2] = wdata[NREQ-1:0];
                A_SW_LSINGLE: st_d.sw[3] = wdata[NREQ-1:0];
                A_TO_CLR:     st_d.clr   = wdata[NREQ-1:0];
                A_TO_TC:      st_d.tc    = wdata[NREQ-1:0];
                A_TO_INT:     st_d.irq   = wdata[1:0];
                default:      st_d       = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign test_mode = st_q.test;
    assign sw_req    = st_q.sw;
    assign to_clr    = st_q.clr;
    assign to_tc     = st_q.tc;
    assign to_int    = st_q.irq;
endmodule

// File: rtl/dmait_req_merge.sv
module dmait_req_merge #(
    parameter int NREQ = 16
) (
    input  logic [NREQ-1:0] hw_req,
    input  logic [NREQ-1:0] sw_req,
    output logic [NREQ-1:0] merged
);
    always_comb merged = hw_req | sw_req;
endmodule

// File: rtl/dmait_out_mux.sv
module dmait_out_mux #(
    parameter int NREQ = 16
) (
    input  logic            test_mode,
    input  logic [NREQ-1:0] core_clr,
    input  logic [NREQ-1:0] core_tc,
    input  logic            core_err,
    input  logic            core_tcint,
    input  logic [NREQ-1:0] to_clr,
    input  logic [NREQ-1:0] to_tc,
    input  logic [1:0]      to_int,
    output logic [NREQ-1:0] pin_clr,
    output logic [NREQ-1:0] pin_tc,
    output logic            pin_err,
    output logic            pin_tcint,
    output logic            pin_any
);
    always_comb begin
        if (test_mode) begin
            pin_clr   = to_clr;
            pin_tc    = to_tc;
            pin_err   = to_int[0];
            pin_tcint = to_int[1];
        end else begin
            pin_clr   = core_clr;
            pin_tc    = core_tc;
            pin_err   = core_err;
            pin_tcint = core_tcint;
        end
        pin_any = pin_err | pin_tcint;
    end
endmodule

// File: rtl/dmait_top.sv
module dmait_top
    import dmait_pkg::*;
#(
    parameter int NREQ = 16,
    parameter int AW   = 8,
    parameter int DW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr_en,
    input  logic [AW-1:0]   reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic [NREQ-1:0] hw_burst_req,
    input  logic [NREQ-1:0] hw_single_req,
    input  logic [NREQ-1:0] hw_lburst_req,
    input  logic [NREQ-1:0] hw_lsingle_req,
    output logic [NREQ-1:0] core_burst_req,
    output logic [NREQ-1:0] core_single_req,
    output logic [NREQ-1:0] core_lburst_req,
    output logic [NREQ-1:0] core_lsingle_req,
    input  logic [NREQ-1:0] core_clr_ack,
    input  logic [NREQ-1:0] core_tc,
    input  logic            core_int_err,
    input  logic            core_int_tc,
    output logic [NREQ-1:0] pin_clr_ack,
    output logic [NREQ-1:0] pin_tc,
    output logic            pin_int_err,
    output logic            pin_int_tc,
    output logic            pin_int_any
);
    logic                            test_mode;
    logic [NUM_GROUPS-1:0][NREQ-1:0] sw_req;
    logic [NUM_GROUPS-1:0][NREQ-1:0] hw_all;
    logic [NUM_GROUPS-1:0][NREQ-1:0] merged;
    logic [NREQ-1:0]                 to_clr, to_tc;
    logic [1:0]                      to_int;
    logic                            rd_in_range;

    dmait_regs #(.NREQ(NREQ), .AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .test_mode(test_mode), .sw_req(sw_req),
        .to_clr(to_clr), .to_tc(to_tc), .to_int(to_int)
    );

    assign hw_all = {hw_lsingle_req, hw_lburst_req, hw_single_req, hw_burst_req};

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_merge
        dmait_req_merge #(.NREQ(NREQ)) u_merge (
            .hw_req(hw_all[g]), .sw_req(sw_req[g]), .merged(merged[g])
        );
    end

    assign core_burst_req   = merged[0];
    assign core_single_req  = merged[1];
    assign core_lburst_req  = merged[2];
    assign core_lsingle_req = merged[3];

    dmait_out_mux #(.NREQ(NREQ)) u_mux (
        .test_mode(test_mode), .core_clr(core_clr_ack), .core_tc(core_tc),
        .core_err(core_int_err), .core_tcint(core_int_tc),
        .to_clr(to_clr), .to_tc(to_tc), .to_int(to_int),
        .pin_clr(pin_clr_ack), .pin_tc(pin_tc), .pin_err(pin_int_err),
        .pin_tcint(pin_int_tc), .pin_any(pin_int_any)
    );

    assign rd_in_range = ((reg_addr >> 3) == '0);

    always_comb begin
        reg_rdata = '0;
        if (rd_in_range) begin
            case (dmait_addr_e'(reg_addr[2:0]))
                A_CTRL:       reg_rdata[0]      = test_mode;
                A_SW_BURST:   reg_rdata[NREQ-1:0] = merged[0];
                A_SW_SINGLE:  reg_rdata[NREQ-1:0] = merged[1];
                A_SW_LBURST:  reg_rdata[NREQ-1:0] = merged[2];
                A_SW_LSINGLE: reg_rdata[NREQ-1:0] = merged[3];
                A_TO_CLR:     reg_rdata[NREQ-1:0] = pin_clr_ack;
                A_TO_TC:      reg_rdata[NREQ-1:0] = pin_tc;
                A_TO_INT:     reg_rdata[1:0]    = {pin_int_tc, pin_int_err};
                default:      reg_rdata         = '0;
            endcase
        end
    end
endmodule

// File: rtl/dmait_checker.sv
module dmait_checker #(
    parameter int NREQ = 16,
    parameter int AW   = 8,
    parameter int DW   = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_wr_en,
    input logic [AW-1:0]   reg_addr,
    input logic [DW-1:0]   reg_wdata,
    input logic [DW-1:0]   reg_rdata,
    input logic [NREQ-1:0] hw_burst_req,
    input logic [NREQ-1:0] core_burst_req,
    input logic [NREQ-1:0] core_clr_ack,
    input logic [NREQ-1:0] pin_clr_ack,
    input logic            pin_int_err,
    input logic            pin_int_tc,
    input logic            pin_int_any,
    input logic            test_mode,
    input logic [NREQ-1:0] sw_burst
);
    a_r2_hw_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (core_burst_req & hw_burst_req) == hw_burst_req);

    a_r4_sw_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_addr == AW'(1)) |=> $stable(sw_burst));

    a_r5_func_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |-> pin_clr_ack == core_clr_ack);

    a_r6_test_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == AW'(5) && test_mode)
        |=> pin_clr_ack == $past(reg_wdata[NREQ-1:0]));

    a_r8_clr_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == AW'(5)) |-> reg_rdata[NREQ-1:0] == pin_clr_ack);

    a_r9_any: assert property (@(posedge clk) disable iff (!rst_n)
        pin_int_any == (pin_int_err | pin_int_tc));

    a_r10_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr > AW'(7)) |-> reg_rdata == '0);
endmodule

bind dmait_top dmait_checker #(.NREQ(NREQ), .AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hw_burst_req(hw_burst_req), .core_burst_req(core_burst_req),
    .core_clr_ack(core_clr_ack), .pin_clr_ack(pin_clr_ack),
    .pin_int_err(pin_int_err), .pin_int_tc(pin_int_tc),
    .pin_int_any(pin_int_any), .test_mode(test_mode), .sw_burst(sw_req[0])
);

// File: tb/sim_dmait_top.sv
`timescale 1ns/1ps
module sim_dmait_top;
    localparam int CLK_P = 10;
    localparam int NREQ  = 16;
    localparam int AW    = 8;
    localparam int DW    = 32;

    logic            clk = 0;
    logic            rst_n = 0;
    logic            reg_wr_en = 0;
    logic [AW-1:0]   reg_addr = '0;
    logic [DW-1:0]   reg_wdata = '0;
    logic [DW-1:0]   reg_rdata;
    logic [NREQ-1:0] hw_b = '0, hw_s = '0, hw_lb = '0, hw_ls = '0;
    logic [NREQ-1:0] c_b, c_s, c_lb, c_ls;
    logic [NREQ-1:0] core_clr = '0, core_tc = '0;
    logic            core_err = 0, core_tci = 0;
    logic [NREQ-1:0] p_clr, p_tc;
    logic            p_err, p_tci, p_any;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    dmait_top #(.NREQ(NREQ), .AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hw_burst_req(hw_b), .hw_single_req(hw_s),
        .hw_lburst_req(hw_lb), .hw_lsingle_req(hw_ls),
        .core_burst_req(c_b), .core_single_req(c_s),
        .core_lburst_req(c_lb), .core_lsingle_req(c_ls),
        .core_clr_ack(core_clr), .core_tc(core_tc),
        .core_int_err(core_err), .core_int_tc(core_tci),
        .pin_clr_ack(p_clr), .pin_tc(p_tc), .pin_int_err(p_err),
        .pin_int_tc(p_tci), .pin_int_any(p_any)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_wr_en = 1; reg_addr = AW'(a); reg_wdata = d;
        @(posedge clk); #1;
        reg_wr_en = 0;
    endtask

    task automatic rd_check(input string req, input int a, input logic [DW-1:0] exp);
        reg_addr = AW'(a); #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic t_reset;
        rd_check("R1 ctrl", 0, 0);
        for (int a = 1; a <= 4; a++) rd_check("R1 sw", a, 0);
        check("R1 core burst", 32'(c_b), 0);
        check("R1 pins follow core", 32'(p_clr), 32'h1234);
        rd_check("R1 R8 clr readback", 5, 32'h1234);
        rd_check("R1 int readback", 7, 0);
    endtask

    task automatic t_merge;
        @(negedge clk);
        hw_b = 16'h00F0; hw_s = 16'h0001; hw_lb = 16'h0300; hw_ls = 16'h8000; #1;
        check("R2 hw only single", 32'(c_s), 32'h0001);
        wr(1, 32'hFFFF_0F00);
        check("R2 burst merge", 32'(c_b), 32'h0FF0);
        check("R3 no leak to single", 32'(c_s), 32'h0001);
        rd_check("R3 burst readback", 1, 32'h0FF0);
        wr(2, 32'h8000);
        check("R2 single merge", 32'(c_s), 32'h8001);
        rd_check("R3 single readback", 2, 32'h8001);
        wr(3, 32'h0030);
        check("R2 lburst merge", 32'(c_lb), 32'h0330);
        rd_check("R3 lburst readback", 3, 32'h0330);
        wr(4, 32'h8001);
        check("R2 lsingle overlap", 32'(c_ls), 32'h8001);
        rd_check("R3 lsingle readback", 4, 32'h8001);
    endtask

    task automatic t_hold;
        @(negedge clk);
        hw_b = '0; hw_s = '0; hw_lb = '0; hw_ls = '0;
        repeat (5) @(posedge clk);
        #1;
        rd_check("R4 burst held", 1, 32'h0F00);
        check("R4 core burst held", 32'(c_b), 32'h0F00);
        rd_check("R4 lsingle held", 4, 32'h8001);
        wr(1, 0);
        rd_check("R4 burst cleared", 1, 0);
        check("R4 core burst cleared", 32'(c_b), 0);
        rd_check("R4 single untouched", 2, 32'h8000);
    endtask

    task automatic t_func;
        @(negedge clk);
        core_clr = 16'hA5A5; core_tc = 16'h5A5A; core_err = 1; core_tci = 0; #1;
        check("R5 clr follows", 32'(p_clr), 32'hA5A5);
        check("R5 tc follows", 32'(p_tc), 32'h5A5A);
        check("R5 err follows", 32'(p_err), 1);
        check("R9 any from err", 32'(p_any), 1);
        rd_check("R8 int readback func", 7, 32'h1);
        rd_check("R8 tc readback func", 6, 32'h5A5A);
        @(negedge clk);
        core_err = 0; core_tci = 0; #1;
        check("R9 any low", 32'(p_any), 0);
    endtask

    task automatic t_test;
        wr(5, 32'h1111);
        wr(6, 32'h2222);
        wr(7, 32'h2);
        check("R6 no effect in func", 32'(p_clr), 32'hA5A5);
        rd_check("R8 clr readback func", 5, 32'hA5A5);
        wr(0, 1);
        rd_check("R6 ctrl readback", 0, 1);
        check("R6 clr from reg", 32'(p_clr), 32'h1111);
        check("R6 tc from reg", 32'(p_tc), 32'h2222);
        check("R7 err from bit0", 32'(p_err), 0);
        check("R7 tc int from bit1", 32'(p_tci), 1);
        check("R9 any test", 32'(p_any), 1);
        rd_check("R8 clr readback test", 5, 32'h1111);
        rd_check("R8 int readback test", 7, 32'h2);
        @(negedge clk);
        core_clr = 16'hFFFF; core_tci = 1; #1;
        check("R6 core ignored", 32'(p_clr), 32'h1111);
        wr(7, 32'h1);
        check("R7 err bit0", 32'(p_err), 1);
        check("R7 tc int cleared", 32'(p_tci), 0);
        wr(7, 0);
        check("R9 any low in test", 32'(p_any), 0);
        wr(0, 0);
        check("R5 back to core", 32'(p_clr), 32'hFFFF);
        check("R5 tc int back", 32'(p_tci), 1);
        check("R9 any func tc", 32'(p_any), 1);
        @(negedge clk);
        core_tci = 0;
    endtask

    task automatic t_timing;
        wr(0, 1);
        @(negedge clk);
        reg_wr_en = 1; reg_addr = AW'(5); reg_wdata = 32'hBEEF; #1;
        check("R11 before edge", 32'(p_clr), 32'h1111);
        @(posedge clk); #1;
        reg_wr_en = 0;
        check("R11 after edge", 32'(p_clr), 32'hBEEF);
        wr(0, 0);
    endtask

    task automatic t_unmapped;
        wr(8, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'hFF, 32'hFFFF_FFFF);
        rd_check("R10 read 8", 8, 0);
        rd_check("R10 read 0x20", 32'h20, 0);
        rd_check("R10 read 0xFF", 32'hFF, 0);
        rd_check("R10 ctrl unchanged", 0, 0);
        rd_check("R10 burst unchanged", 1, 0);
        rd_check("R10 single unchanged", 2, 32'h8000);
        wr(0, 1);
        rd_check("R10 clr reg unchanged", 5, 32'hBEEF);
        rd_check("R10 int reg unchanged", 7, 0);
        wr(0, 0);
    endtask

    initial begin
        core_clr = 16'h1234;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        #1;
        t_reset();
        t_merge();
        t_hold();
        t_func();
        t_test();
        t_timing();
        t_unmapped();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule